// File: doc/BRIEF.md
# Debounced Level-Interrupt Input Bank

This block watches eight external input pins and turns each one's settled level into an interrupt request. Every pin first passes through a two-stage synchronizer. A per-channel filter then requires the synchronized value to stay unchanged for a programmable number of millisecond ticks before it is accepted as stable. The window is 1 to 4095 ticks, and a programmed window of zero behaves as one tick. Each time a channel settles, it produces one stable event. If the settled level matches that channel's chosen trigger level (high or low), the event sets a pending bit. The pending bit then stays set until software clears it.

Software works through a flat register port. Writes take effect on the clock edge, and reads are combinational. Through this port it selects the trigger level, sets the enable and arm bits, sets the data-read mask, reads the raw and masked pending status, and clears pending bits by writing ones. It also programs one 32-bit control word per channel, whose low 12 bits hold the debounce window. A pending bit reaches the masked status, and from there the single interrupt output, only while both its enable bit and its arm bit are set. Because a channel fires once per stable period, a level that simply stays put never raises the request again once it has been cleared.

Top module: `dbi_bank`

## Requirements
- R1: After reset, every register reads 0 and `irq_o` is low.
- R2: The level-select (0x14), enable (0x18), arm (0x28) and data-mask (0x04) registers keep bits 7:0 and read 0 in bits 31:8. The control word of channel n (0x40 + 4n) reads back all 32 written bits.
- R3: A channel accepts its synchronized input as stable on the Nth tick during which the input has held one value, where N is bits 11:0 of its control word and 0 counts as 1. Any change of the input before that restarts the count.
- R4: Bit n of level-select chooses the trigger level of channel n, with 1 meaning high and 0 meaning low. A stable event at the other level leaves the status unchanged.
- R5: Raw status (0x1C) bit n is set by a stable event at the trigger level, whatever the enable and arm bits hold, and it stays set until cleared.
- R6: Masked status (0x20) is raw AND enable AND arm, and `irq_o` is high exactly when any masked bit is set.
- R7: Writing 1 to bit n of the clear register (0x24) clears raw bit n, and 0 bits have no effect. If a clear and a new event hit the same channel in the same cycle, the event wins. The clear register reads 0.
- R8: A channel fires once per stable period. After it has fired and been cleared, further ticks do not set it again until its input changes and settles again.
- R9: Data (0x00) bit n returns channel n's last accepted stable level while data-mask bit n is 1, and 0 otherwise.
- R10: The pin input passes through two synchronizer flops, so ticks within the first three edges after a pin change do not count toward the new value. Channels act independently, and bit n of each register always belongs to channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| ms_tick | input | 1 | One-cycle millisecond pulse |
| pin_in | input | 8 | Asynchronous raw input pins |
| irq_o | output | 1 | OR of masked status |

## Verification
The bench first lets a freshly reset bank settle at low levels with mixed trigger levels. Only the channels set to low-level triggering may fire, which separates the level-select behaviour from the raw latch. A single high pulse, held until enable and arm are both set, distinguishes raw status from masked status and from the interrupt. A held pin that receives further ticks, and a pin changed while ticks are already running, expose any repeated firing and the synchronizer latency. A glitch in the middle of a five-tick window, after four ticks have already counted, shows whether the count restarts or merely pauses.

// File: rtl/dbi_pkg.sv
package dbi_pkg;
  localparam int CNT_W = 12;

  localparam logic [7:0] OFF_DATA = 8'h00;
  localparam logic [7:0] OFF_DMSK = 8'h04;
  localparam logic [7:0] OFF_LVL  = 8'h14;
  localparam logic [7:0] OFF_EN   = 8'h18;
  localparam logic [7:0] OFF_RAW  = 8'h1C;
  localparam logic [7:0] OFF_MSK  = 8'h20;
  localparam logic [7:0] OFF_CLR  = 8'h24;
  localparam logic [7:0] OFF_ARM  = 8'h28;
  localparam logic [7:0] OFF_CTRL = 8'h40;

  // effective debounce window: zero is treated as a single tick
  function automatic logic [CNT_W-1:0] eff_limit(input logic [CNT_W-1:0] fld);
    return (fld == '0) ? CNT_W'(1) : fld;
  endfunction

  // byte offset of channel control word
  function automatic logic [7:0] ctrl_off(input int ch);
    return OFF_CTRL + 8'(ch * 4);
  endfunction
endpackage

// File: rtl/dbi_sync.sv
module dbi_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [STAGES-1:0] chain [WIDTH];

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[b] <= '0;
      else        chain[b] <= {chain[b][STAGES-2:0], d_in[b]};
    end
    assign d_out[b] = chain[b][STAGES-1];
  end
endmodule

// File: rtl/dbi_chan_filter.sv
module dbi_chan_filter #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          fire,
  output logic          cand,
  output logic [CW-1:0] cnt
);
  logic        settled;
  logic [CW:0] nxt;

  assign nxt  = {1'b0, cnt} + (CW+1)'(1);
  assign fire = (smp == cand) && tick && !settled && (nxt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand    <= 1'b0;
      cnt     <= '0;
      settled <= 1'b0;
    end else if (smp != cand) begin
      cand    <= smp;
      cnt     <= '0;
      settled <= 1'b0;
    end else if (fire) begin
      settled <= 1'b1;
      cnt     <= nxt[CW-1:0];
    end else if (tick && !settled) begin
      cnt     <= nxt[CW-1:0];
    end
  end
endmodule

// File: rtl/dbi_bank.sv
module dbi_bank
  import dbi_pkg::*;
#(
  parameter int N_CH = 8,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [AW-1:0]   reg_addr,
  input  logic [DW-1:0]   reg_wdata,
  output logic [DW-1:0]   reg_rdata,
  input  logic            ms_tick,
  input  logic [N_CH-1:0] pin_in,
  output logic            irq_o
);
  localparam int PAD = DW - N_CH;

  logic [N_CH-1:0]  pin_s;
  logic [N_CH-1:0]  lvl_q, en_q, arm_q, dmsk_q, raw_q, data_q;
  logic [DW-1:0]    ctrl_q [N_CH];
  logic [N_CH-1:0]  fire_vec, cand_vec, evt_vec, clr_vec, masked;
  logic [CNT_W-1:0] cnt_vec [N_CH];

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] off);
    return a == AW'(off);
  endfunction

  dbi_sync #(.WIDTH(N_CH), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(pin_in), .d_out(pin_s)
  );

  for (genvar n = 0; n < N_CH; n++) begin : g_ch
    dbi_chan_filter #(.CW(CNT_W)) u_filt (
      .clk(clk), .rst_n(rst_n), .smp(pin_s[n]), .tick(ms_tick),
      .limit(eff_limit(ctrl_q[n][CNT_W-1:0])),
      .fire(fire_vec[n]), .cand(cand_vec[n]), .cnt(cnt_vec[n])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[n] <= '0;
      else if (reg_wr && hit(reg_addr, ctrl_off(n))) ctrl_q[n] <= reg_wdata;
    end
  end

  assign evt_vec = fire_vec & ~(cand_vec ^ lvl_q);
  assign clr_vec = (reg_wr && hit(reg_addr, OFF_CLR)) ? reg_wdata[N_CH-1:0] : '0;
  assign masked  = raw_q & en_q & arm_q;
  assign irq_o   = |masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      en_q   <= '0;
      arm_q  <= '0;
      dmsk_q <= '0;
      raw_q  <= '0;
      data_q <= '0;
    end else begin
      if (reg_wr && hit(reg_addr, OFF_LVL))  lvl_q  <= reg_wdata[N_CH-1:0];
      if (reg_wr && hit(reg_addr, OFF_EN))   en_q   <= reg_wdata[N_CH-1:0];
      if (reg_wr && hit(reg_addr, OFF_ARM))  arm_q  <= reg_wdata[N_CH-1:0];
      if (reg_wr && hit(reg_addr, OFF_DMSK)) dmsk_q <= reg_wdata[N_CH-1:0];
      raw_q  <= (raw_q & ~clr_vec) | evt_vec;
      data_q <= (data_q & ~fire_vec) | (cand_vec & fire_vec);
    end
  end

  always_comb begin
    reg_rdata = '0;
    if      (hit(reg_addr, OFF_DATA)) reg_rdata = {{PAD{1'b0}}, data_q & dmsk_q};
    else if (hit(reg_addr, OFF_DMSK)) reg_rdata = {{PAD{1'b0}}, dmsk_q};
    else if (hit(reg_addr, OFF_LVL))  reg_rdata = {{PAD{1'b0}}, lvl_q};
    else if (hit(reg_addr, OFF_EN))   reg_rdata = {{PAD{1'b0}}, en_q};
    else if (hit(reg_addr, OFF_RAW))  reg_rdata = {{PAD{1'b0}}, raw_q};
    else if (hit(reg_addr, OFF_MSK))  reg_rdata = {{PAD{1'b0}}, masked};
    else if (hit(reg_addr, OFF_ARM))  reg_rdata = {{PAD{1'b0}}, arm_q};
    else begin
      for (int i = 0; i < N_CH; i++) begin
        if (hit(reg_addr, ctrl_off(i))) reg_rdata = ctrl_q[i];
      end
    end
  end
endmodule

// File: rtl/dbi_bank_chk.sv
module dbi_bank_chk #(
  parameter int N_CH = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq_o,
  input logic [N_CH-1:0] raw_q,
  input logic [N_CH-1:0] en_q,
  input logic [N_CH-1:0] arm_q,
  input logic [N_CH-1:0] evt_vec,
  input logic [N_CH-1:0] fire_vec,
  input logic [N_CH-1:0] clr_vec
);
  for (genvar n = 0; n < N_CH; n++) begin : g_a
    AST_RAW_FROM_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[n]) |-> $past(evt_vec[n])); // R5
    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_q[n] && !clr_vec[n]) |=> raw_q[n]); // R5
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[n] && !evt_vec[n]) |=> !raw_q[n]); // R7
    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      evt_vec[n] |=> raw_q[n]); // R7
    AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_vec[n] |=> !fire_vec[n]); // R8
  end

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(en_q & arm_q))); // R6
  AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|raw_q)); // R6
endmodule

bind dbi_bank dbi_bank_chk #(.N_CH(N_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .raw_q(raw_q), .en_q(en_q),
  .arm_q(arm_q), .evt_vec(evt_vec), .fire_vec(fire_vec), .clr_vec(clr_vec)
);

// File: tb/tb_dbi_bank.sv
module tb_dbi_bank;
  localparam time PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        ms_tick = 1'b0;
  logic [7:0]  pin_in = '0;
  logic        irq_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  typedef struct {
    bit          is_irq;
    logic [7:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #(PERIOD/2) clk = ~clk;

  dbi_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ms_tick(ms_tick),
    .pin_in(pin_in), .irq_o(irq_o)
  );

  // monitor: pop expectations and compare away from the active edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it  = sb.pop_front();
      act = it.is_irq ? {31'b0, irq_o} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    reg_addr = a;
    it.is_irq = 0; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic irq_chk(input logic e, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.is_irq = 1; it.addr = '0; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; ms_tick = 1'b1;
      @(posedge clk); #1; ms_tick = 1'b0;
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk(8'h1C, 32'h0, "R1 raw after reset");
    rd_chk(8'h20, 32'h0, "R1 masked after reset");
    rd_chk(8'h00, 32'h0, "R1 data after reset");
    rd_chk(8'h40, 32'h0, "R1 ctrl0 after reset");
    irq_chk(1'b0, "R1 irq after reset");

    // R2 register widths
    wr(8'h14, 32'hFFFF_FF0F);
    rd_chk(8'h14, 32'h0000_000F, "R2 level select width");
    wr(8'h48, 32'hABCD_E005);
    rd_chk(8'h48, 32'hABCD_E005, "R2 ctrl word readback");

    // R4/R5: first tick settles all idle-low channels except ch2 (window 5)
    tick(1);
    rd_chk(8'h1C, 32'h0000_00F0, "R4 low-level channels fire");
    rd_chk(8'h20, 32'h0, "R6 masked needs enable");
    irq_chk(1'b0, "R6 irq low while disabled");

    // R7 write-one-to-clear
    wr(8'h24, 32'h30);
    rd_chk(8'h1C, 32'h0000_00C0, "R7 partial clear");
    wr(8'h24, 32'h00);
    rd_chk(8'h1C, 32'h0000_00C0, "R7 zero write no effect");
    rd_chk(8'h24, 32'h0, "R7 clear reads zero");
    wr(8'h24, 32'hC0);
    rd_chk(8'h1C, 32'h0, "R7 full clear");

    // R8 no refire on a held level; ch2 settles low against high level (R4)
    tick(4);
    rd_chk(8'h1C, 32'h0, "R8 held level does not refire");

    // R6 enable and arm gating
    wr(8'h18, 32'h01);
    pin_in[0] = 1'b1;
    settle();
    tick(1);
    rd_chk(8'h1C, 32'h0000_0001, "R4 high-level event ch0");
    rd_chk(8'h20, 32'h0, "R6 masked needs arm");
    irq_chk(1'b0, "R6 irq low while unarmed");
    wr(8'h28, 32'h01);
    rd_chk(8'h20, 32'h0000_0001, "R6 masked with enable and arm");
    irq_chk(1'b1, "R6 irq asserted");
    rd_chk(8'h00, 32'h0, "R9 data hidden by mask");
    wr(8'h04, 32'h01);
    rd_chk(8'h00, 32'h0000_0001, "R9 data visible with mask");
    wr(8'h24, 32'h01);
    irq_chk(1'b0, "R7 irq drops after clear");
    tick(2);
    rd_chk(8'h1C, 32'h0, "R8 ch0 stays quiet after clear");

    // R10 synchronizer latency: ticks during first edges do not count
    @(posedge clk); #1;
    pin_in[1] = 1'b1; ms_tick = 1'b1;
    repeat (3) @(posedge clk);
    #1 ms_tick = 1'b0;
    rd_chk(8'h1C, 32'h0, "R10 ticks before sync ignored");
    tick(1);
    rd_chk(8'h1C, 32'h0000_0002, "R10 ch1 fires alone");
    wr(8'h24, 32'h02);

    // R3 debounce window with restart on glitch (ch2 window 5)
    wr(8'h18, 32'h05);
    wr(8'h28, 32'h05);
    pin_in[2] = 1'b1;
    settle();
    tick(4);
    rd_chk(8'h1C, 32'h0, "R3 not stable after 4 of 5 ticks");
    pin_in[2] = 1'b0;
    settle();
    pin_in[2] = 1'b1;
    settle();
    tick(4);
    rd_chk(8'h1C, 32'h0, "R3 glitch restarts count");
    tick(1);
    rd_chk(8'h1C, 32'h0000_0004, "R3 fires on fifth tick");
    irq_chk(1'b1, "R3 irq from ch2");
    wr(8'h04, 32'h05);
    rd_chk(8'h00, 32'h0000_0005, "R9 stable levels ch0 ch2");

    repeat (2) @(posedge clk);
    finished = 1;
    finish_run();
  end
endmodule